// File: doc/BRIEF.md
# EDH Error Flag Processor

This block works out the outgoing error-status flags for one video field of an error detection and handling (EDH) path. It takes two inputs. The first is the set of flags decoded from the incoming error packet, with an indication of whether that packet was present. The second is the local results of the active-picture CRC check, the full-field CRC check and the ancillary checksum check. From these it forms fifteen outgoing flags: five kinds (error detected here, error detected already, internal error here, internal error already, unknown status) for each of three classes (active picture, full field, ancillary).

Flags that arrive from upstream are recoded one step along the chain. The host can force each flag to a value or leave it transparent, and can make flags sticky. A per-flag sensitivity register selects which flags raise an active-low interrupt and advance a saturating count of errored fields. All field results are taken on a single end-of-field strobe. In transmit mode every flag goes to zero.

Flag word encoding (used on `in_flags`, `flags_out` and the mask registers): class base AP=0, FF=5, ANC=10. Offsets from the base are +0 EDH, +1 EDA, +2 IDH, +3 IDA, +4 UES. Sensitivity word: bits 4c+0..4c+3 give EDH, EDA, IDH and IDA for class c (AP=0, FF=1, ANC=2), and bit 12 covers UES in all classes. Host addresses: 0 write forced values / read flag word; 1 force enables; 2 sensitivity; 3 control (bit0 sticky, bit1 clear-count action, bit2 auto-clear); 4 read counter.

Top module: `edh_flag_proc`

## Requirements
- R1: After reset the flag word is 0, `irq_n` is 1, the counter reads 0, control and force enables read 0, and sensitivity reads 0x1FFF.
- R2: With a packet present, the AP and FF EDH flags equal the local CRC mismatch of their class, and ANC EDH equals the local checksum error.
- R3: With a packet present, the outgoing AP and FF EDA is the incoming EDA OR (the incoming EDH AND `crc_valid`). With `crc_valid` low, it follows the incoming EDA alone.
- R4: With a packet present, outgoing ANC EDA is the incoming ANC EDH OR EDA. Outgoing IDA in each class is the incoming IDH OR IDA. Outgoing IDH comes only from forcing.
- R5: With no packet, UES is 1 in all classes, all other flags are 0, and ANC EDH still reports the checksum error.
- R6: With a packet present, each class's UES follows the incoming UES of that class.
- R7: In transmit mode the field result is all zeros whatever the inputs and force settings.
- R8: In receive mode a flag whose enable bit is 1 takes the forced value, and a flag whose enable bit is 0 is transparent.
- R9: Without sticky, each field replaces the flag word. With sticky (control bit0), set flags accumulate across fields until a host read of address 0, which restores the latest field's flags.
- R10: The counter advances by one at an end-of-field whose flags hit an enabled sensitivity bit. Sensitivity bit 12 alone governs UES of all three classes.
- R11: The counter (21 bits by default) holds at all ones instead of wrapping.
- R12: `irq_n` goes low at an end-of-field with a sensitive hit and stays low until any host read.
- R13: Writing control bit1 clears the counter. With auto-clear set, each read of address 4 clears it after returning its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| field_end | input | 1 | End-of-field strobe, one cycle |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| pkt_present | input | 1 | Field carried an error packet |
| crc_valid | input | 1 | Incoming CRC-valid bit |
| ap_crc_err | input | 1 | Active-picture CRC mismatch |
| ff_crc_err | input | 1 | Full-field CRC mismatch |
| anc_sum_err | input | 1 | Ancillary checksum error |
| in_flags | input | 15 | Incoming flags |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, combinational on address |
| flags_out | output | 15 | Outgoing flag word |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench attacks the recoding corners. An incoming EDH with the CRC-valid bit low must not become EDA; a design that ignored that bit would report errors already detected upstream. With no packet present, CRC mismatches must vanish while the ancillary checksum error survives; a design that cleared everything would lose ancillary errors. Further tests cover forcing under transmit mode, and sticky flags released by a read to the latest field rather than to zero. A narrow second instance checks counter saturation, where a wrapping counter would read back a small number. Sensitivity masking, the UES bit that covers all classes, and clear-on-read are each checked against counts a wrong gate would miss.

// File: rtl/edh_flag_proc.sv
module edh_flag_proc #(
  parameter int CNT_W = 21,
  parameter int AW    = 3,
  parameter int DW    = (CNT_W > 15) ? CNT_W : 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_end,
  input  logic          tx_mode,
  input  logic          pkt_present,
  input  logic          crc_valid,
  input  logic          ap_crc_err,
  input  logic          ff_crc_err,
  input  logic          anc_sum_err,
  input  logic [14:0]   in_flags,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [14:0]   flags_out,
  output logic          irq_n
);
  localparam int NCLS = 3;
  localparam int FPC  = 5;
  localparam int NF   = NCLS * FPC;
  localparam int NS   = NCLS * 4 + 1;
  localparam logic [AW-1:0] A_FLAGS = AW'(0);
  localparam logic [AW-1:0] A_MEN   = AW'(1);
  localparam logic [AW-1:0] A_SENS  = AW'(2);
  localparam logic [AW-1:0] A_CTRL  = AW'(3);
  localparam logic [AW-1:0] A_CNT   = AW'(4);

  logic [NF-1:0]    raw, masked, nxt_flags, fld_q, flags_q, mask_val_q, mask_en_q, sens_x;
  logic [NS-1:0]    sens_q;
  logic             sticky_q, autoclr_q, irq_q, hit, cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt_q;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam int B = FPC * c;
    logic loc_err, i_edh, i_eda, i_idh, i_ida, i_ues;
    assign {i_ues, i_ida, i_idh, i_eda, i_edh} = in_flags[B +: FPC];
    if (c == 0) begin : g_ap
      assign loc_err = ap_crc_err;
    end else if (c == 1) begin : g_ff
      assign loc_err = ff_crc_err;
    end else begin : g_anc
      assign loc_err = anc_sum_err;
    end
    if (c == NCLS - 1) begin : g_sum
      assign raw[B+0] = loc_err;
      assign raw[B+1] = pkt_present && (i_eda || i_edh);
    end else begin : g_crc
      assign raw[B+0] = pkt_present && loc_err;
      assign raw[B+1] = pkt_present && (i_eda || (i_edh && crc_valid));
    end
    assign raw[B+2] = 1'b0;
    assign raw[B+3] = pkt_present && (i_idh || i_ida);
    assign raw[B+4] = !pkt_present || i_ues;
    assign sens_x[B +: FPC] = {sens_q[NS-1], sens_q[4*c +: 4]};
  end

  assign masked    = tx_mode ? '0 : ((raw & ~mask_en_q) | (mask_val_q & mask_en_q));
  assign nxt_flags = tx_mode ? '0 : (sticky_q ? (masked | flags_q) : masked);
  assign hit       = |(nxt_flags & sens_x);
  assign cnt_inc   = field_end && hit;
  assign cnt_clr   = (host_wr && host_addr == A_CTRL && host_wdata[1]) ||
                     (host_rd && host_addr == A_CNT && autoclr_q);
  assign flags_out = flags_q;
  assign irq_n     = ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q   <= '0;
      flags_q <= '0;
    end else if (field_end) begin
      fld_q   <= masked;
      flags_q <= nxt_flags;
    end else if (host_rd && host_addr == A_FLAGS && sticky_q) begin
      flags_q <= fld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_val_q <= '0;
      mask_en_q  <= '0;
      sens_q     <= '1;
      sticky_q   <= 1'b0;
      autoclr_q  <= 1'b0;
    end else if (host_wr) begin
      case (host_addr)
        A_FLAGS: mask_val_q <= host_wdata[NF-1:0];
        A_MEN:   mask_en_q  <= host_wdata[NF-1:0];
        A_SENS:  sens_q     <= host_wdata[NS-1:0];
        A_CTRL:  begin
          sticky_q  <= host_wdata[0];
          autoclr_q <= host_wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_clr)          cnt_q <= cnt_inc ? CNT_W'(1) : '0;
    else if (cnt_inc && !(&cnt_q)) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (cnt_inc) irq_q <= 1'b1;
    else if (host_rd) irq_q <= 1'b0;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_FLAGS: host_rdata[NF-1:0] = flags_q;
      A_MEN:   host_rdata[NF-1:0] = mask_en_q;
      A_SENS:  host_rdata[NS-1:0] = sens_q;
      A_CTRL:  host_rdata[2:0]    = {autoclr_q, 1'b0, sticky_q};
      A_CNT:   host_rdata[CNT_W-1:0] = cnt_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/edh_flag_proc_chk.sv
module edh_flag_proc_chk #(
  parameter int CNT_W = 21,
  parameter int AW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          field_end,
  input logic          tx_mode,
  input logic          pkt_present,
  input logic          host_wr,
  input logic          host_rd,
  input logic [AW-1:0] host_addr,
  input logic [14:0]   flags_out,
  input logic [14:0]   mask_en_q,
  input logic          irq_n,
  input logic [CNT_W-1:0] cnt_q
);
  p_tx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_end && tx_mode |=> flags_out == 15'd0);

  p_ues_nopkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_end && !tx_mode && !pkt_present && !mask_en_q[4] |=> flags_out[4]);

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end && !(host_rd && host_addr == AW'(0)) |=> $stable(flags_out));

  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end && !host_wr && !host_rd |=> $stable(cnt_q));

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr && !host_rd |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q) && !host_wr && !host_rd |=> (&cnt_q));

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n && !host_rd |=> !irq_n);

  p_irq_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !field_end |=> irq_n);
endmodule

bind edh_flag_proc edh_flag_proc_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_end(field_end), .tx_mode(tx_mode),
  .pkt_present(pkt_present), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .flags_out(flags_out), .mask_en_q(mask_en_q),
  .irq_n(irq_n), .cnt_q(cnt_q)
);

// File: tb/test_edh_flag_proc.sv
module test_edh_flag_proc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_end = 0, tx_mode = 0, pkt_present = 0, crc_valid = 0;
  logic ap_crc_err = 0, ff_crc_err = 0, anc_sum_err = 0;
  logic [14:0] in_flags = '0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = '0;
  logic [20:0] host_wdata = '0;
  logic [20:0] host_rdata;
  logic [14:0] flags_out, sat_flags;
  logic irq_n, sat_irq_n;
  logic [14:0] sat_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edh_flag_proc i_edh_flag_proc (
    .clk(clk), .rst_n(rst_n), .field_end(field_end), .tx_mode(tx_mode),
    .pkt_present(pkt_present), .crc_valid(crc_valid), .ap_crc_err(ap_crc_err),
    .ff_crc_err(ff_crc_err), .anc_sum_err(anc_sum_err), .in_flags(in_flags),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .flags_out(flags_out),
    .irq_n(irq_n));

  edh_flag_proc #(.CNT_W(3)) i_sat (
    .clk(clk), .rst_n(rst_n), .field_end(field_end), .tx_mode(tx_mode),
    .pkt_present(pkt_present), .crc_valid(crc_valid), .ap_crc_err(ap_crc_err),
    .ff_crc_err(ff_crc_err), .anc_sum_err(anc_sum_err), .in_flags(in_flags),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata[14:0]), .host_rdata(sat_rdata), .flags_out(sat_flags),
    .irq_n(sat_irq_n));

  // {tx, pkt, crc_valid, ap_err, ff_err, anc_err, in_flags, expected}
  localparam logic [35:0] VEC [15] = '{
    {6'b010000, 15'h0000, 15'h0000},
    {6'b011100, 15'h0000, 15'h0001},
    {6'b011011, 15'h0000, 15'h0420},
    {6'b011000, 15'h0021, 15'h0042},
    {6'b010000, 15'h0021, 15'h0000},
    {6'b010000, 15'h0002, 15'h0002},
    {6'b011000, 15'h0400, 15'h0800},
    {6'b011000, 15'h0800, 15'h0800},
    {6'b011000, 15'h1084, 15'h2108},
    {6'b011000, 15'h0008, 15'h0008},
    {6'b011000, 15'h4210, 15'h4210},
    {6'b000110, 15'h7FFF, 15'h4210},
    {6'b000001, 15'h0000, 15'h4610},
    {6'b111111, 15'h7FFF, 15'h0000},
    {6'b011100, 15'h0001, 15'h0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_field(input logic [5:0] ctl, input logic [14:0] inf);
    @(negedge clk);
    {tx_mode, pkt_present, crc_valid, ap_crc_err, ff_crc_err, anc_sum_err} = ctl;
    in_flags = inf;
    field_end = 1'b1;
    @(negedge clk);
    field_end = 1'b0;
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [20:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [20:0] d, output logic [14:0] ds);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1;
    d = host_rdata; ds = sat_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [20:0] rd;
    logic [14:0] rs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", 32'(flags_out), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    hread(3'd2, rd, rs); chk("R1 sens", 32'(rd), 32'h1FFF);
    hread(3'd3, rd, rs); chk("R1 ctrl", 32'(rd), 0);
    hread(3'd1, rd, rs); chk("R1 mask enables", 32'(rd), 0);
    hread(3'd4, rd, rs); chk("R1 counter", 32'(rd), 0);

    for (int i = 0; i < 15; i++) begin
      do_field(VEC[i][35:30], VEC[i][29:15]);
      chk($sformatf("R2 R3 R4 R5 R6 R7 row %0d", i), 32'(flags_out), 32'(VEC[i][14:0]));
    end

    // R8 masking: AP EDH forced 1, ANC EDA forced 0, FF EDH transparent
    hwrite(3'd0, 21'h0001);
    hwrite(3'd1, 21'h0801);
    do_field(6'b011010, 15'h0400);
    chk("R8 force and transparent", 32'(flags_out), 32'h0021);
    do_field(6'b111111, 15'h7FFF);
    chk("R7 tx overrides force", 32'(flags_out), 0);
    hwrite(3'd1, 21'h0);

    // R9 sticky
    hwrite(3'd3, 21'h1);
    do_field(6'b011100, 15'h0); chk("R9 sticky set", 32'(flags_out), 32'h0001);
    do_field(6'b011000, 15'h0); chk("R9 sticky hold", 32'(flags_out), 32'h0001);
    do_field(6'b011010, 15'h0); chk("R9 sticky accumulate", 32'(flags_out), 32'h0021);
    hread(3'd0, rd, rs);        chk("R9 read flag word", 32'(rd), 32'h0021);
    chk("R9 read restores latest field", 32'(flags_out), 32'h0020);
    do_field(6'b011000, 15'h0); chk("R9 hold after read", 32'(flags_out), 32'h0020);
    hread(3'd0, rd, rs);        chk("R9 second release", 32'(flags_out), 0);
    hwrite(3'd3, 21'h0);
    do_field(6'b011100, 15'h0); chk("R9 plain set", 32'(flags_out), 32'h0001);
    do_field(6'b011000, 15'h0); chk("R9 plain replace", 32'(flags_out), 0);

    // R10 R12 R13 counter and interrupt
    hwrite(3'd3, 21'h2);
    hread(3'd4, rd, rs); chk("R13 clear by write", 32'(rd), 0);
    chk("R12 irq released by read", 32'(irq_n), 1);
    hwrite(3'd2, 21'h0010);
    do_field(6'b011100, 15'h0);
    chk("R12 insensitive flag no irq", 32'(irq_n), 1);
    hread(3'd4, rd, rs); chk("R10 insensitive no count", 32'(rd), 0);
    do_field(6'b011010, 15'h0);
    chk("R12 irq asserted", 32'(irq_n), 0);
    do_field(6'b011000, 15'h0);
    chk("R12 irq held", 32'(irq_n), 0);
    hread(3'd4, rd, rs); chk("R10 count one", 32'(rd), 1);
    chk("R12 irq cleared by read", 32'(irq_n), 1);
    hread(3'd4, rd, rs); chk("R13 no auto clear", 32'(rd), 1);
    hwrite(3'd2, 21'h1000);
    do_field(6'b000000, 15'h0);
    do_field(6'b011000, 15'h4000);
    hread(3'd4, rd, rs); chk("R10 shared UES bit", 32'(rd), 3);
    hwrite(3'd3, 21'h4);
    hread(3'd4, rd, rs); chk("R13 auto clear returns value", 32'(rd), 3);
    hread(3'd4, rd, rs); chk("R13 auto clear cleared", 32'(rd), 0);

    // R11 saturation on the narrow instance
    hwrite(3'd3, 21'h2);
    hwrite(3'd2, 21'h1FFF);
    for (int k = 0; k < 9; k++) do_field(6'b000000, 15'h0);
    hread(3'd4, rd, rs);
    chk("R10 nine fields", 32'(rd), 9);
    chk("R11 saturate", 32'(rs), 7);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule